// File: doc/BRIEF.md
# Lockable GPIO Bank Controller

This block is a register-mapped bank of general-purpose I/O pins. Each pin has a direction bit, an output data bit, a polarity invert bit and a drive-mode bit. The drive-mode bit chooses between push-pull output and emulated open-drain output. In open-drain mode the pin is released for a one and pulled low for a zero. The bank has nine dedicated pins at bit positions 8:0. It also has two groups of pins that are shared with other functions: four pins at bits 19:16 and five pins at bits 28:24. A shared pin is driven by this block only while software has enabled it for GPIO use.

Software reaches the bank through a single-cycle 32-bit register write port and a combinational read port, both addressed by a 3-bit word index. The pin side has three 32-bit vectors: an input vector from the pads, an output-value vector and an output-enable vector. A sticky lock bit freezes the data and drive-mode registers until the next reset. Pad inputs pass through a two-flop synchronizer before software can read them.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0 and no pin is driven (pinOe = 0, pinOut = 0).
- R2: A write to the data register (word index 3) changes only the bits of pins whose direction bit is 1 (output). Data bits of input pins keep their stored value.
- R3: A data register read returns the stored bit for output pins and the synchronized pad value for input pins. A pad change becomes visible on the second rising clock edge after it occurs, and not on the first.
- R4: The value a pin drives is its data bit XOR its invert bit (invert register, word index 1, 1 = invert).
- R5: For an active output pin with drive-mode bit 1 (drive-mode register, word index 2, byte offset 08h), pinOe is 1 and pinOut equals the driven value.
- R6: For an active output pin with drive-mode bit 0, the pin has pinOe 0 when the value is 1. When the value is 0, it has pinOe 1 and pinOut 0. pinOut is never 1 in this mode.
- R7: A pin whose direction bit is 0 (direction register, word index 0) has pinOe 0 and pinOut 0, whatever its drive-mode, invert and data bits are.
- R8: A shared pin (bits 19:16 and 28:24) is driven only while its bit in the share-enable register (word index 4) is 1. Dedicated pins (bits 8:0) need no enable.
- R9: Writing 1 to bit 0 of the lock register (word index 5) sets the lock. While locked, writes to the data and drive-mode registers have no effect, and the direction and invert registers stay writable. Writing 0 does not clear the lock. Only reset clears it.
- R10: Reserved bit positions ignore writes, read as 0 in every register and are never driven. The valid pin mask is 1F0F01FFh, and the share-enable mask is 1F0F0000h. Word indexes 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word index for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at addr (combinational) |
| pinIn | input | 32 | Pad input values (asynchronous) |
| pinOut | output | 32 | Value presented to each pad driver |
| pinOe | output | 32 | Output enable for each pad driver |

## Verification
The hardest situation to reach from the ports involves a data bit that was written while its pin was an output and then kept while that pin was an input. The stored value is then hidden behind the synchronized pad value on reads. The stimulus makes a partial-direction data write and then widens the direction to all outputs. This exposes the stored bits and shows that the input bits were never overwritten. The lock is set in the middle of the run, and the stimulus then tries data and drive-mode writes that must bounce off while direction writes still land. A second reset shows that only reset clears the lock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [REG_W-1:0] DEF_DED_MASK = 32'h0000_01FF;
  localparam logic [REG_W-1:0] DEF_SHR_MASK = 32'h1F0F_0000;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR = 3'd0,
    REG_INV = 3'd1,
    REG_DRV = 3'd2,
    REG_DAT = 3'd3,
    REG_SHR = 3'd4,
    REG_LCK = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrInv;
    logic wrDrv;
    logic wrDat;
    logic wrShr;
    logic setLock;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic          lockBit,
  output wrStrobe_t     strobe,
  output logic          lockQ
);

  wrStrobe_t rawStrobe;

  always_comb begin
    rawStrobe = '0;
    if (wrEn) begin
      case (addr)
        REG_DIR: rawStrobe.wrDir   = 1'b1;
        REG_INV: rawStrobe.wrInv   = 1'b1;
        REG_DRV: rawStrobe.wrDrv   = 1'b1;
        REG_DAT: rawStrobe.wrDat   = 1'b1;
        REG_SHR: rawStrobe.wrShr   = 1'b1;
        REG_LCK: rawStrobe.setLock = lockBit;
        default: rawStrobe = '0;
      endcase
    end
  end

  // frozen fields lose their strobes while the lock is held
  always_comb begin
    strobe       = rawStrobe;
    strobe.wrDat = rawStrobe.wrDat & ~lockQ;
    strobe.wrDrv = rawStrobe.wrDrv & ~lockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockQ <= 1'b0;
    else if (strobe.setLock) lockQ <= 1'b1;
  end

endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int             W        = REG_W,
  parameter int             AW       = ADDR_W,
  parameter logic [W-1:0]   DED_MASK = DEF_DED_MASK,
  parameter logic [W-1:0]   SHR_MASK = DEF_SHR_MASK
) (
  input  logic          clk,
  input  logic          rstN,
  input  wrStrobe_t     strobe,
  input  logic [W-1:0]  wrData,
  input  logic [AW-1:0] addr,
  input  logic          lockQ,
  input  logic [W-1:0]  pinIn,
  output logic [W-1:0]  rdData,
  output logic [W-1:0]  pinOut,
  output logic [W-1:0]  pinOe,
  output logic [W-1:0]  dirQ,
  output logic [W-1:0]  invQ,
  output logic [W-1:0]  drvQ,
  output logic [W-1:0]  datQ,
  output logic [W-1:0]  shrQ
);

  localparam logic [W-1:0] PIN_MASK = DED_MASK | SHR_MASK;

  logic [W-1:0] syncA, syncB;
  logic [W-1:0] datView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      invQ <= '0;
      drvQ <= '0;
      datQ <= '0;
      shrQ <= '0;
    end else begin
      if (strobe.wrDir) dirQ <= wrData & PIN_MASK;
      if (strobe.wrInv) invQ <= wrData & PIN_MASK;
      if (strobe.wrDrv) drvQ <= wrData & PIN_MASK;
      if (strobe.wrShr) shrQ <= wrData & SHR_MASK;
      if (strobe.wrDat) datQ <= (datQ & ~dirQ) | (wrData & dirQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn & PIN_MASK;
      syncB <= syncA;
    end
  end

  assign datView = (datQ & dirQ) | (syncB & ~dirQ);

  always_comb begin
    case (addr)
      REG_DIR: rdData = dirQ;
      REG_INV: rdData = invQ;
      REG_DRV: rdData = drvQ;
      REG_DAT: rdData = datView;
      REG_SHR: rdData = shrQ;
      REG_LCK: rdData = {{(W-1){1'b0}}, lockQ};
      default: rdData = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : gPin
    if (PIN_MASK[i]) begin : gUsed
      logic isGpio, active, level;
      assign isGpio    = DED_MASK[i] | shrQ[i];
      assign active    = dirQ[i] & isGpio;
      assign level     = datQ[i] ^ invQ[i];
      assign pinOe[i]  = active & (drvQ[i] | ~level);
      assign pinOut[i] = active & drvQ[i] & level;
    end else begin : gRsvd
      assign pinOe[i]  = 1'b0;
      assign pinOut[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int           W        = REG_W,
  parameter int           AW       = ADDR_W,
  parameter logic [W-1:0] DED_MASK = DEF_DED_MASK,
  parameter logic [W-1:0] SHR_MASK = DEF_SHR_MASK
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  input  logic [W-1:0]  pinIn,
  output logic [W-1:0]  pinOut,
  output logic [W-1:0]  pinOe
);

  wrStrobe_t    strobe;
  logic         lockQ;
  logic [W-1:0] dirQ, invQ, drvQ, datQ, shrQ;

  gpio_bank_ctrl #(.AW(AW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .lockBit (wrData[0]),
    .strobe  (strobe),
    .lockQ   (lockQ)
  );

  gpio_bank_dpath #(
    .W(W), .AW(AW), .DED_MASK(DED_MASK), .SHR_MASK(SHR_MASK)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .addr   (addr),
    .lockQ  (lockQ),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .dirQ   (dirQ),
    .invQ   (invQ),
    .drvQ   (drvQ),
    .datQ   (datQ),
    .shrQ   (shrQ)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int           W        = REG_W,
  parameter int           AW       = ADDR_W,
  parameter logic [W-1:0] DED_MASK = DEF_DED_MASK,
  parameter logic [W-1:0] SHR_MASK = DEF_SHR_MASK
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  pinOut,
  input logic [W-1:0]  pinOe,
  input logic [W-1:0]  dirQ,
  input logic [W-1:0]  drvQ,
  input logic [W-1:0]  datQ,
  input logic [W-1:0]  shrQ,
  input logic          lockQ
);

  localparam logic [W-1:0] PIN_MASK = DED_MASK | SHR_MASK;

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(datQ) && $stable(drvQ)));

  a_r7_input_undriven: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~dirQ) == '0) && ((pinOut & ~dirQ) == '0));

  a_r6_open_drain_no_high: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~drvQ) == '0);

  a_r5_out_implies_oe: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  a_r8_shared_gated: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & SHR_MASK & ~shrQ) == '0);

  a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe | pinOut) & ~PIN_MASK) == '0);

  a_r2_input_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_DAT) |=> (((datQ ^ $past(datQ)) & ~$past(dirQ)) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(
  .W(W), .AW(AW), .DED_MASK(DED_MASK), .SHR_MASK(SHR_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .pinOut(pinOut), .pinOe(pinOe), .dirQ(dirQ), .drvQ(drvQ),
  .datQ(datQ), .shrQ(shrQ), .lockQ(lockQ)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;

  int nChk = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  typedef struct packed {
    logic [31:0] dir, inv, drv, dat, expOut, expOe, expRd;
  } vec_t;

  // R4 R5 R6 R7 pattern table (pinIn held at 0)
  localparam vec_t VEC [6] = '{
    '{32'hF, 32'h0, 32'hF, 32'h5, 32'h5, 32'hF, 32'h5},
    '{32'hF, 32'hF, 32'hF, 32'h5, 32'hA, 32'hF, 32'h5},
    '{32'hF, 32'h0, 32'h0, 32'h5, 32'h0, 32'hA, 32'h5},
    '{32'h3, 32'h0, 32'hF, 32'hF, 32'h3, 32'h3, 32'h3},
    '{32'hF, 32'h3, 32'hC, 32'h6, 32'h4, 32'hE, 32'h6},
    '{32'h0, 32'hF, 32'hF, 32'hF, 32'h0, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset oe", pinOe, 32'h0);
    check("R1 reset out", pinOut, 32'h0);

    // table walk
    for (int k = 0; k < 6; k++) begin
      wr(REG_DIR, 32'h1FF);
      wr(REG_DAT, 32'h0);
      wr(REG_DIR, VEC[k].dir);
      wr(REG_INV, VEC[k].inv);
      wr(REG_DRV, VEC[k].drv);
      wr(REG_DAT, VEC[k].dat);
      rd(REG_DAT, v);
      check("R4/R5/R6/R7 out", pinOut, VEC[k].expOut);
      check("R4/R5/R6/R7 oe", pinOe, VEC[k].expOe);
      check("R2 data readback", v, VEC[k].expRd);
    end

    // R10 reserved bits
    wr(REG_DIR, 32'hFFFF_FFFF);
    rd(REG_DIR, v);
    check("R10 dir mask", v, 32'h1F0F_01FF);
    wr(REG_SHR, 32'hFFFF_FFFF);
    rd(REG_SHR, v);
    check("R10 share mask", v, 32'h1F0F_0000);
    rd(3'd6, v);
    check("R10 index 6 zero", v, 32'h0);

    // R8 shared gating
    wr(REG_SHR, 32'h0);
    wr(REG_INV, 32'h0);
    wr(REG_DRV, 32'hFFFF_FFFF);
    wr(REG_DAT, 32'hFFFF_FFFF);
    check("R8 shared disabled oe", pinOe, 32'h0000_01FF);
    wr(REG_SHR, 32'h000F_0000);
    check("R8 group enabled oe", pinOe, 32'h000F_01FF);
    check("R10 reserved never driven", pinOut, 32'h000F_01FF);

    // R3 synchronizer latency on input pins
    wr(REG_DIR, 32'h0);
    @(negedge clk);
    pinIn = 32'hFFFF_FFFF;
    addr = REG_DAT;
    @(negedge clk);
    check("R3 one edge not visible", rdData, 32'h0);
    @(negedge clk);
    check("R3 two edges visible", rdData, 32'h1F0F_01FF);
    pinIn = 32'h0;
    repeat (2) @(negedge clk);

    // R2 input data bits retained
    wr(REG_DIR, 32'h1FF);
    wr(REG_DAT, 32'h0);
    wr(REG_DIR, 32'h00F);
    wr(REG_DAT, 32'h0FF);
    rd(REG_DAT, v);
    check("R2 partial read", v, 32'h00F);
    wr(REG_DIR, 32'h1FF);
    rd(REG_DAT, v);
    check("R2 input bits untouched", v, 32'h00F);

    // R9 lock
    wr(REG_DRV, 32'h1FF);
    wr(REG_LCK, 32'h1);
    rd(REG_LCK, v);
    check("R9 lock set", v, 32'h1);
    wr(REG_DAT, 32'h1F0);
    rd(REG_DAT, v);
    check("R9 data frozen", v, 32'h00F);
    wr(REG_DRV, 32'h0);
    rd(REG_DRV, v);
    check("R9 drive frozen", v, 32'h1FF);
    check("R9 pins still push-pull", pinOe, 32'h1FF);
    wr(REG_DIR, 32'h003);
    rd(REG_DIR, v);
    check("R9 dir writable", v, 32'h003);
    wr(REG_INV, 32'h001);
    check("R9 invert writable out", pinOut, 32'h002);
    wr(REG_LCK, 32'h0);
    rd(REG_LCK, v);
    check("R9 lock not cleared by write", v, 32'h1);
    doReset();
    rd(REG_LCK, v);
    check("R9 reset clears lock", v, 32'h0);
    wr(REG_DIR, 32'h1FF);
    wr(REG_DAT, 32'h0AA);
    rd(REG_DAT, v);
    check("R9 data writable after reset", v, 32'h0AA);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule